// File: doc/BRIEF.md
# One-shot down-counting interrupt timer

This block is a 32-bit timer for register-bus access. Software loads a start value, selects one of four count sources and enables the timer. The counter then counts down by one on each strobe from the selected source. When it reaches zero it raises a pending status and stops there. It does not restart. Software disables the timer, writes a new start value and enables it again to start another timeout. A level interrupt is driven from the pending status, gated by an interrupt enable.

The four count sources are synchronous single-cycle strobes in the block's clock domain: a slow 32 kHz tick, a reference tick, a CPU-rate tick and a bus-rate tick. The block does not generate, divide or multiplex clocks, so several instances can share one set of strobes. The register bus has single-cycle read and write strobes and a combinational read path. The start value can only be changed while the timer is stopped, and the live count reads as zero while it is stopped.

Top module: `irq_dntimer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The control word at offset 0x0 holds only the run bit (bit 0) and the source field (bits 5:4). A read returns those bits, and all other bits read zero. Source field encoding: 0 selects `tick_i[0]` (32 kHz), 1 selects `tick_i[1]` (reference), 2 selects `tick_i[2]` (CPU rate) and 3 selects `tick_i[3]` (bus rate).
- R3: A write to the start-value register at offset 0x4 takes effect only while the run bit is 0. While the timer runs, the write is ignored and a read of 0x4 still returns the old value.
- R4: While the run bit is 0, the live count at offset 0x8 reads zero.
- R5: A control write that changes the run bit from 0 to 1 loads the live count with the start value at that edge.
- R6: While the timer runs and the count is nonzero, the count decreases by exactly one on each cycle where the selected strobe is high. Strobes on the other three sources have no effect.
- R7: When the count reaches zero, the pending status (offset 0xC, bit 4 on read) sets. The count then stays at zero and is not reloaded.
- R8: `irq_o` is high exactly when the pending status is set and the interrupt enable is set. A write to offset 0xC loads the interrupt enable from bit 4 of the write data.
- R9: A write to offset 0xC with bit 5 set clears the pending status. If an expiry happens in the same cycle, the status stays set.
- R10: A start value of zero makes the run phase hold at zero and never sets the pending status.
- R11: Writing 0 to bit 4 at offset 0xC drops `irq_o` and leaves the pending status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe; rdata_o is valid in the same cycle |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero when rd_en_i is low |
| tick_i | input | 4 | Count-source strobes, one bit per source |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can act on the pending status in the same cycle: a software clear through the acknowledge register and a hardware expiry on the final selected strobe. The bench arms the timer with a start value of two and lets one strobe pass. It then issues the clear write in the same cycle as the second strobe. The status must read set afterwards, because the expiry wins. A separate clear with no strobe must read cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned SRC_W     = $clog2(NUM_SRC);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_START  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 4'hC;

  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned SRC_LSB   = 4;
  localparam int unsigned IE_BIT    = 4;
  localparam int unsigned CLR_BIT   = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_REF  = 2'd1,
    SRC_CPU  = 2'd2,
    SRC_BUS  = 2'd3
  } src_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = SRC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          start_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          run_q_o,
  output logic          run_nx_o,
  output logic [SW-1:0] src_q_o,
  output logic [DW-1:0] start_q_o,
  output logic          arm_o
);
  logic          run_q, run_d;
  logic [SW-1:0] src_q, src_d;
  logic [DW-1:0] start_q, start_d;
  logic          start_en;

  always_comb begin
    run_d    = run_q;
    src_d    = src_q;
    if (ctrl_we_i) begin
      run_d = wdata_i[RUN_BIT];
      src_d = wdata_i[SRC_LSB +: SW];
    end
    start_en = start_we_i && !run_q;
    start_d  = start_en ? wdata_i : start_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      src_q <= '0;
    end else if (ctrl_we_i) begin
      run_q <= run_d;
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
    end else if (start_en) begin
      start_q <= start_d;
    end
  end

  assign run_q_o   = run_q;
  assign run_nx_o  = run_d;
  assign src_q_o   = src_q;
  assign start_q_o = start_q;
  assign arm_o     = ctrl_we_i && wdata_i[RUN_BIT] && !run_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_q_i,
  input  logic          run_nx_i,
  input  logic          arm_i,
  input  logic          tick_i,
  input  logic [DW-1:0] start_i,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          dec;
  logic          cnt_en;

  always_comb begin
    dec      = run_q_i && run_nx_i && !arm_i && tick_i && (cnt_q != '0);
    expire_o = dec && (cnt_q == DW'(1));
    if (arm_i) begin
      cnt_d = start_i;
    end else if (!run_nx_i) begin
      cnt_d = '0;
    end else if (dec) begin
      cnt_d = cnt_q - DW'(1);
    end else begin
      cnt_d = cnt_q;
    end
    cnt_en = arm_i || dec || !run_nx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_i,
  output logic          status_o,
  output logic          ie_o,
  output logic          irq_o
);
  logic status_q, status_d;
  logic ie_q, ie_d;

  always_comb begin
    status_d = status_q;
    if (ack_we_i && wdata_i[CLR_BIT]) status_d = 1'b0;
    if (expire_i)                     status_d = 1'b1;
    ie_d = ack_we_i ? wdata_i[IE_BIT] : ie_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      ie_q     <= 1'b0;
    end else begin
      status_q <= status_d;
      if (ack_we_i) ie_q <= ie_d;
    end
  end

  assign status_o = status_q;
  assign ie_o     = ie_q;
  assign irq_o    = status_q && ie_q;
endmodule

// File: rtl/irq_dntimer.sv
module irq_dntimer
  import tmr_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned NS  = NUM_SRC,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NS-1:0] tick_i,
  output logic          irq_o
);
  localparam int unsigned SW = $clog2(NS);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  logic          ctrl_we, start_we, ack_we;
  logic          run_q, run_nx, arm;
  logic [SW-1:0] src_q;
  logic [DW-1:0] start_q, count_q;
  logic          tick_sel, expire, status_q, ie_q;

  always_comb begin
    ctrl_we  = wr_en_i && (addr_i == OFS_CTRL);
    start_we = wr_en_i && (addr_i == OFS_START);
    ack_we   = wr_en_i && (addr_i == OFS_ACK);
    tick_sel = tick_i[src_q];
  end

  tmr_regs #(.DW(DW), .SW(SW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .ctrl_we_i  (ctrl_we),
    .start_we_i (start_we),
    .wdata_i    (wdata_i),
    .run_q_o    (run_q),
    .run_nx_o   (run_nx),
    .src_q_o    (src_q),
    .start_q_o  (start_q),
    .arm_o      (arm)
  );

  tmr_counter #(.DW(DW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_sn),
    .run_q_i  (run_q),
    .run_nx_i (run_nx),
    .arm_i    (arm),
    .tick_i   (tick_sel),
    .start_i  (start_q),
    .count_o  (count_q),
    .expire_o (expire)
  );

  tmr_irq #(.DW(DW)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_sn),
    .ack_we_i (ack_we),
    .wdata_i  (wdata_i),
    .expire_i (expire),
    .status_o (status_q),
    .ie_o     (ie_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        OFS_CTRL: begin
          rdata_o[RUN_BIT]        = run_q;
          rdata_o[SRC_LSB +: SW]  = src_q;
        end
        OFS_START: rdata_o = start_q;
        OFS_COUNT: rdata_o = run_q ? count_q : '0;
        OFS_ACK:   rdata_o[IE_BIT] = status_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_dntimer_chk.sv
module irq_dntimer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_sn,
  input logic          ctrl_we,
  input logic          start_we,
  input logic          ack_we,
  input logic [DW-1:0] wdata_i,
  input logic          run_q,
  input logic          arm,
  input logic [DW-1:0] start_q,
  input logic [DW-1:0] count_q,
  input logic          tick_sel,
  input logic          expire,
  input logic          status_q,
  input logic          irq_o
);
  p_start_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (run_q && start_we) |=> $stable(start_q));

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (!run_q && !arm) |=> (count_q == '0));

  p_arm_load_r5: assert property (@(posedge clk_i) disable iff (!rst_sn)
    arm |=> (run_q && count_q == $past(start_q)));

  p_no_tick_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (run_q && !tick_sel && !ctrl_we) |=> $stable(count_q));

  p_tick_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (run_q && tick_sel && !ctrl_we && count_q != '0) |=> (count_q == $past(count_q) - 1));

  p_hold_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (run_q && !ctrl_we && count_q == '0) |=> (count_q == '0));

  p_expire_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_sn)
    expire |=> status_q);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (ack_we && wdata_i[5] && !expire) |=> !status_q);

  p_irq_needs_status_r8: assert property (@(posedge clk_i) disable iff (!rst_sn)
    irq_o |-> status_q);

  p_irq_off_r11: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (ack_we && !wdata_i[4]) |=> !irq_o);
endmodule

bind irq_dntimer irq_dntimer_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_sn   (rst_sn),
  .ctrl_we  (ctrl_we),
  .start_we (start_we),
  .ack_we   (ack_we),
  .wdata_i  (wdata_i),
  .run_q    (run_q),
  .arm      (arm),
  .start_q  (start_q),
  .count_q  (count_q),
  .tick_sel (tick_sel),
  .expire   (expire),
  .status_q (status_q),
  .irq_o    (irq_o)
);

// File: tb/irq_dntimer_tb_top.sv
`timescale 1ns/1ps
module irq_dntimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  tick;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_dntimer dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .tick_i  (tick),
    .irq_o   (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] t = 4'h0);
    wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0; tick = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic step(input logic [3:0] t);
    tick = t;
    @(posedge clk); #1;
    tick = 4'h0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0; tick = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v); check("R1 reset read", v, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 control readback
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, v); check("R2 ctrl mask", v, 32'h30);
    wr(4'h0, 32'h0000_0020);
    rd(4'h0, v); check("R2 ctrl src", v, 32'h20);

    // interrupt enable on, status clear
    wr(4'hC, 32'h30);

    // R4 R5 R6 R7 sweep over source and start value
    for (int s = 0; s < 4; s++) begin
      for (int r = 1; r <= 6; r++) begin
        int exp_cnt;
        bit exp_st;
        wr(4'h0, 32'h0);
        wr(4'hC, 32'h30);
        wr(4'h4, 32'(r));
        rd(4'h4, v); check("R3 start write while stopped", v, 32'(r));
        rd(4'h8, v); check("R4 count zero while stopped", v, 32'h0);
        wr(4'h0, 32'(s << 4) | 32'h1);
        rd(4'h8, v); check("R5 load on enable", v, 32'(r));
        exp_cnt = r; exp_st = 1'b0;
        for (int k = 0; k < 40; k++) begin
          logic [3:0] t;
          t = 4'((k * 11 + s * 7 + r * 3) % 16);
          step(t);
          if (t[s] && exp_cnt != 0) begin
            exp_cnt--;
            if (exp_cnt == 0) exp_st = 1'b1;
          end
          rd(4'h8, v); check("R6 R7 count", v, 32'(exp_cnt));
          rd(4'hC, v); check("R7 status", v, {27'b0, exp_st, 4'b0});
          check("R8 irq", {31'b0, irq}, {31'b0, exp_st});
        end
      end
    end

    // R3 start write ignored while running
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h9);
    wr(4'h0, 32'h11);
    wr(4'h4, 32'h55);
    rd(4'h4, v); check("R3 start ignored while running", v, 32'h9);
    rd(4'h8, v); check("R3 count unchanged", v, 32'h9);

    // R9 plain clear
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h1);
    wr(4'h0, 32'h11);
    step(4'h2);
    rd(4'hC, v); check("R7 expire sets status", v, 32'h10);
    wr(4'hC, 32'h30);
    rd(4'hC, v); check("R9 clear", v, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);

    // R9 clear and expiry in same cycle
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h2);
    wr(4'h0, 32'h31);
    step(4'h8);
    rd(4'h8, v); check("R6 one step", v, 32'h1);
    wr(4'hC, 32'h30, 4'h8);
    rd(4'hC, v); check("R9 set wins over clear", v, 32'h10);
    check("R8 irq with set status", {31'b0, irq}, 32'h1);

    // R11 enable off keeps status
    wr(4'hC, 32'h0);
    check("R11 irq dropped", {31'b0, irq}, 32'h0);
    rd(4'hC, v); check("R11 status kept", v, 32'h10);
    wr(4'hC, 32'h10);
    check("R8 irq back on enable", {31'b0, irq}, 32'h1);

    // R10 zero start value
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h30);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h1);
    for (int k = 0; k < 5; k++) step(4'hF);
    rd(4'h8, v); check("R10 count stays zero", v, 32'h0);
    rd(4'hC, v); check("R10 no status", v, 32'h0);

    // R4 count reads zero after disable
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h7);
    wr(4'h0, 32'h1);
    wr(4'h0, 32'h0);
    rd(4'h8, v); check("R4 zero after disable", v, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule